// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decoder

This block is the test access port of a chip's boundary-scan logic. It runs the standard sixteen-state controller on the test clock, which is steered by the mode input. It holds a five-bit instruction and uses that instruction to decide which data register sits between the serial input and the serial output. The choices are a one-bit pass-through register, a 32-bit identification word, or a boundary register that lives outside the block. The boundary register is reached through capture, shift and update strobes and a serial return line.

A board tester drives the four serial pins. The boundary register, 232 cells on the chip this block targets, hooks onto the `bsr_*` signals and uses `extest_mode` to hand the pads over to the scan cells. The serial output changes on the falling clock edge. It comes with an enable that the pad ring uses to drive the pin only while a shift is in progress. The controller and the instruction return to their reset values through the active-low asynchronous reset, or through five rising edges with the mode input held high.

Top module: `jtag_tap_core`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset, `ir_out` reads 00001 (identification) and `tdo_en` is 0, whatever the state of the clock.
- R2: Five rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state, and `ir_out` is 00001 right after the fifth edge. After four such edges from Shift-DR, the instruction is unchanged.
- R3: Capture-IR loads the instruction shift stage with 00001, so the two low bits read 01 and the upper three bits read 000. Shift-IR then sends the stage out LSB first on `tdo`.
- R4: `ir_out` takes the shifted value only at the rising edge that leaves Update-IR. During Shift-IR and Exit1-IR it keeps the old value.
- R5: With opcode 00001, Capture-DR loads the 32-bit word {version 4'h0, part number, manufacturer code 11'b00000100000, 1'b1}, MSB to LSB, and Shift-DR sends it out LSB first.
- R6: Opcode 11111 selects a one-bit register that captures 0 and delays `tdi` by one shift.
- R7: Any opcode other than 00000, 00001, 00010 and 11111 behaves exactly as 11111.
- R8: Opcodes 00000 and 00010 route `bsr_tdo` to `tdo`. Under these opcodes, `bsr_capture`, `bsr_shift` and `bsr_update` are high during Capture-DR, Shift-DR and Update-DR respectively, and at most one of them is high at a time. Under any other opcode all three stay low. `extest_mode` is high only for 00000.
- R9: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high exactly in the low phases that follow entry into, or a stay in, Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; may be stopped at either level |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries shift data; the pad driver uses it |
| ir_out | output | 5 | Active instruction |
| bsr_tdo | input | 1 | Serial return from the boundary register |
| bsr_capture | output | 1 | Boundary register capture strobe |
| bsr_shift | output | 1 | Boundary register shift strobe |
| bsr_update | output | 1 | Boundary register update strobe |
| extest_mode | output | 1 | Boundary cells own the pads |

## Verification
The controller state advances on each rising edge. Capture, shift and update all act on the rising edge that leaves their state, while `tdo` and `tdo_en` follow on the next falling edge, half a cycle later. The bench drives `tms` and `tdi` and samples `tdo` one nanosecond after each falling edge, so every serial bit is read in the low phase before the edge that shifts it. The first bit read after Capture is the captured LSB. The falling-edge timing of `tdo` is checked by sampling just after a rising edge (old bit still present) and just after the next falling edge (new bit present). The instruction is checked in the Update-IR low phase (old value) and after the edge that leaves that state (new value). The strobes are read in the low phase of Capture-DR.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  localparam int IR_W = 5;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST  = 5'b00000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 5'b00001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 5'b00010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SDRS, ST_CDR, ST_SDR, ST_E1DR, ST_PDR, ST_E2DR,
    ST_UDR, ST_SIRS, ST_CIR, ST_SIR, ST_E1IR, ST_PIR, ST_E2IR, ST_UIR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYPASS, PATH_IDCODE, PATH_BOUNDARY} dr_path_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_TLR:  return m ? ST_TLR  : ST_RTI;
      ST_RTI:  return m ? ST_SDRS : ST_RTI;
      ST_SDRS: return m ? ST_SIRS : ST_CDR;
      ST_CDR:  return m ? ST_E1DR : ST_SDR;
      ST_SDR:  return m ? ST_E1DR : ST_SDR;
      ST_E1DR: return m ? ST_UDR  : ST_PDR;
      ST_PDR:  return m ? ST_E2DR : ST_PDR;
      ST_E2DR: return m ? ST_UDR  : ST_SDR;
      ST_UDR:  return m ? ST_SDRS : ST_RTI;
      ST_SIRS: return m ? ST_TLR  : ST_CIR;
      ST_CIR:  return m ? ST_E1IR : ST_SIR;
      ST_SIR:  return m ? ST_E1IR : ST_SIR;
      ST_E1IR: return m ? ST_UIR  : ST_PIR;
      ST_PIR:  return m ? ST_E2IR : ST_PIR;
      ST_E2IR: return m ? ST_UIR  : ST_SIR;
      ST_UIR:  return m ? ST_SDRS : ST_RTI;
      default: return ST_TLR;
    endcase
  endfunction

  // Unlisted opcodes fall through to the pass-through register.
  function automatic dr_path_e decode_path(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: return PATH_BOUNDARY;
      OP_IDCODE:            return PATH_IDCODE;
      default:              return PATH_BYPASS;
    endcase
  endfunction

  function automatic logic [ID_W-1:0] make_id(input logic [3:0] ver,
                                              input logic [15:0] part,
                                              input logic [10:0] mfr);
    return {ver, part, mfr, 1'b1};
  endfunction
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st,
  output logic       ev_cap_ir,
  output logic       ev_sh_ir,
  output logic       ev_upd_ir,
  output logic       ev_cap_dr,
  output logic       ev_sh_dr,
  output logic       ev_upd_dr,
  output logic       ev_enter_tlr
);
  tap_state_e st_nxt;

  always_comb st_nxt = tap_next(st, tms);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= st_nxt;
  end

  assign ev_cap_ir    = (st == ST_CIR);
  assign ev_sh_ir     = (st == ST_SIR);
  assign ev_upd_ir    = (st == ST_UIR);
  assign ev_cap_dr    = (st == ST_CDR);
  assign ev_sh_dr     = (st == ST_SDR);
  assign ev_upd_dr    = (st == ST_UDR);
  assign ev_enter_tlr = (st_nxt == ST_TLR);
endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            cap,
  input  logic            sh,
  input  logic            upd,
  input  logic            clr,
  output logic            ir_so,
  output logic [IR_W-1:0] ir_q
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  ir_sr <= IR_CAPTURE;
    else if (cap) ir_sr <= IR_CAPTURE;
    else if (sh)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  // Shadow register: moves only on leaving Update-IR, or on reaching reset.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  ir_q <= OP_IDCODE;
    else if (clr) ir_q <= OP_IDCODE;
    else if (upd) ir_q <= ir_sr;
  end

  assign ir_so = ir_sr[0];
endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic     tck,
  input  logic     trst_n,
  input  logic     tdi,
  input  dr_path_e path,
  input  logic     cap,
  input  logic     sh,
  output logic     byp_so,
  output logic     id_so
);
  logic            byp_q;
  logic [ID_W-1:0] id_sr;
  logic            byp_act;
  logic            id_act;

  assign byp_act = (path == PATH_BYPASS);
  assign id_act  = (path == PATH_IDCODE);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)            byp_q <= 1'b0;
    else if (byp_act & cap) byp_q <= 1'b0;
    else if (byp_act & sh)  byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           id_sr <= ID_VALUE;
    else if (id_act & cap) id_sr <= ID_VALUE;
    else if (id_act & sh)  id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  assign byp_so = byp_q;
  assign id_so  = id_sr[0];
endmodule

// File: rtl/jtag_tap_core.sv
module jtag_tap_core
  import jtag_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [15:0] ID_PART    = 16'h4A21,
  parameter logic [10:0] ID_MFR     = 11'b00000100000
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  output logic [IR_W-1:0] ir_out,
  input  logic            bsr_tdo,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            extest_mode
);
  localparam logic [ID_W-1:0] ID_WORD = make_id(ID_VERSION, ID_PART, ID_MFR);

  tap_state_e st;
  logic ev_cap_ir, ev_sh_ir, ev_upd_ir, ev_cap_dr, ev_sh_dr, ev_upd_dr, ev_enter_tlr;
  logic ir_so, byp_so, id_so, ser_out;
  dr_path_e path;

  jtag_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st),
    .ev_cap_ir(ev_cap_ir), .ev_sh_ir(ev_sh_ir), .ev_upd_ir(ev_upd_ir),
    .ev_cap_dr(ev_cap_dr), .ev_sh_dr(ev_sh_dr), .ev_upd_dr(ev_upd_dr),
    .ev_enter_tlr(ev_enter_tlr)
  );

  jtag_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(ev_cap_ir), .sh(ev_sh_ir), .upd(ev_upd_ir), .clr(ev_enter_tlr),
    .ir_so(ir_so), .ir_q(ir_out)
  );

  assign path = decode_path(ir_out);

  jtag_tap_dr #(.ID_VALUE(ID_WORD)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .path(path),
    .cap(ev_cap_dr), .sh(ev_sh_dr), .byp_so(byp_so), .id_so(id_so)
  );

  assign bsr_capture = ev_cap_dr & (path == PATH_BOUNDARY);
  assign bsr_shift   = ev_sh_dr  & (path == PATH_BOUNDARY);
  assign bsr_update  = ev_upd_dr & (path == PATH_BOUNDARY);
  assign extest_mode = (ir_out == OP_EXTEST);

  always_comb begin
    if (ev_sh_ir) ser_out = ir_so;
    else begin
      case (path)
        PATH_IDCODE:   ser_out = id_so;
        PATH_BOUNDARY: ser_out = bsr_tdo;
        default:       ser_out = byp_so;
      endcase
    end
  end

  // Output stage retimed to the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= ser_out;
      tdo_en <= ev_sh_ir | ev_sh_dr;
    end
  end
endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input tap_state_e      st,
  input logic            tdo,
  input logic            tdo_en,
  input logic [IR_W-1:0] ir_out,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update
);
  // R2
  tlr_holds_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR) |-> (ir_out == OP_IDCODE));

  // R4
  ir_only_on_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_out) |-> ($past(st) == ST_UIR || st == ST_TLR));

  // R3
  ir_capture_lsb_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(st) == ST_CIR && st == ST_SIR) |-> (tdo == 1'b1));

  // R6
  bypass_captures_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(st) == ST_CDR && st == ST_SDR && ir_out == OP_BYPASS) |-> (tdo == 1'b0));

  // R8
  strobes_exclusive_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  // R8
  strobes_need_boundary_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_capture | bsr_shift | bsr_update) |-> (ir_out == OP_EXTEST || ir_out == OP_SAMPLE));

  // R9
  tdo_en_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (st == ST_SIR || st == ST_SDR));
endmodule

bind jtag_tap_core jtag_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .st(st), .tdo(tdo), .tdo_en(tdo_en),
  .ir_out(ir_out), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
  .bsr_update(bsr_update)
);

// File: tb/tb_jtag_tap_core.sv
module tb_jtag_tap_core;
  localparam int          BSR_LEN = 232;
  localparam logic [15:0] PART    = 16'h4A21;
  localparam logic [31:0] EXP_ID  = {4'h0, PART, 11'b00000100000, 1'b1};
  localparam logic [BSR_LEN-1:0] BSR_CAPV = {8{29'h0B5A3C71}};

  logic tck = 1'b0, trst_n = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, bsr_tdo, bsr_capture, bsr_shift, bsr_update, extest_mode;
  logic [4:0] ir_out;
  int total = 0, bad = 0, upd_cnt = 0;
  logic cap_seen;
  logic [BSR_LEN-1:0] bsr_m = '0;

  always #4 tck = ~tck;

  jtag_tap_core #(.ID_VERSION(4'h0), .ID_PART(PART), .ID_MFR(11'b00000100000)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .ir_out(ir_out), .bsr_tdo(bsr_tdo), .bsr_capture(bsr_capture),
    .bsr_shift(bsr_shift), .bsr_update(bsr_update), .extest_mode(extest_mode)
  );

  // Bench model of the external boundary register.
  always @(posedge tck) begin
    if (bsr_capture)    bsr_m <= BSR_CAPV;
    else if (bsr_shift) bsr_m <= {tdi, bsr_m[BSR_LEN-1:1]};
    if (bsr_update)     upd_cnt <= upd_cnt + 1;
  end
  assign bsr_tdo = bsr_m[0];

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic jbit(input logic m, input logic d, output logic o);
    tms = m; tdi = d; o = tdo;
    @(posedge tck); #1;
    @(negedge tck); #1;
  endtask

  task automatic do_reset();
    logic o;
    tms = 1'b1;
    trst_n = 1'b0;
    #20;
    trst_n = 1'b1;
    @(negedge tck); #1;
    jbit(1'b0, 1'b0, o);
  endtask

  // From Run-Test/Idle through one IR scan, back to Run-Test/Idle.
  task automatic scan_ir(input logic [4:0] din, output logic [4:0] dout,
                         output logic [4:0] ir_in_upd);
    logic o;
    jbit(1, 0, o); jbit(1, 0, o); jbit(0, 0, o); jbit(0, 0, o);
    for (int i = 0; i < 5; i++) jbit(i == 4, din[i], dout[i]);
    jbit(1, 0, o);
    ir_in_upd = ir_out;
    jbit(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [255:0] din, output logic [255:0] dout);
    logic o;
    dout = '0;
    jbit(1, 0, o); jbit(0, 0, o);
    cap_seen = bsr_capture;
    jbit(0, 0, o);
    for (int i = 0; i < n; i++) jbit(i == n - 1, din[i], dout[i]);
    jbit(1, 0, o); jbit(0, 0, o);
  endtask

  task automatic t_reset();
    trst_n = 1'b0; #2;
    chk("R1 ir_out under trst", ir_out, 5'b00001);
    chk("R1 tdo_en under trst", tdo_en, 1'b0);
    #18; trst_n = 1'b1;
    @(negedge tck); #1;
    begin logic o; jbit(0, 0, o); end
    chk("R1 ir_out after reset", ir_out, 5'b00001);
  endtask

  task automatic t_idcode();
    logic [255:0] d;
    scan_dr(32, '0, d);
    chk("R5 id word", d[31:0], EXP_ID);
    chk("R8 no bsr capture under idcode", cap_seen, 1'b0);
  endtask

  task automatic t_ir_capture_and_update();
    logic [4:0] d, held;
    scan_ir(5'b11111, d, held);
    chk("R3 ir capture value", d, 5'b00001);
    chk("R4 ir held through update state", held, 5'b00001);
    chk("R4 ir after update", ir_out, 5'b11111);
  endtask

  task automatic t_bypass(input logic [4:0] op, input string tag);
    logic [4:0] d, held;
    logic [255:0] din, dout, exp;
    scan_ir(op, d, held);
    din = 256'h0; din[7:0] = 8'b1011_0110;
    scan_dr(8, din, dout);
    exp = '0; exp[7:1] = din[6:0];
    chk(tag, dout[7:0], exp[7:0]);
    chk({tag, " no bsr capture"}, cap_seen, 1'b0);
  endtask

  task automatic t_tdo_edge();
    logic o, t1, t2;
    jbit(1, 0, o); jbit(0, 0, o); jbit(0, 0, o);
    chk("R9 tdo_en in shift-dr", tdo_en, 1'b1);
    chk("R6 bypass captured 0", tdo, 1'b0);
    tms = 0; tdi = 1;
    @(posedge tck); #1; t1 = tdo;
    @(negedge tck); #1; t2 = tdo;
    chk("R9 tdo held after rising edge", t1, 1'b0);
    chk("R9 tdo updated after falling edge", t2, 1'b1);
    jbit(1, 0, o);
    chk("R9 tdo_en low in exit1", tdo_en, 1'b0);
    jbit(1, 0, o); jbit(0, 0, o);
  endtask

  task automatic t_boundary(input logic [4:0] op, input logic ext, input string tag);
    logic [4:0] d, held;
    logic [255:0] din, dout;
    int u0;
    scan_ir(op, d, held);
    chk({tag, " R8 extest_mode"}, extest_mode, ext);
    din = {8{32'hC3A51E69}};
    u0 = upd_cnt;
    scan_dr(BSR_LEN, din, dout);
    chk({tag, " R8 capture strobe"}, cap_seen, 1'b1);
    chk({tag, " R8 bsr data on tdo"}, dout[BSR_LEN-1:0], BSR_CAPV);
    chk({tag, " R8 bsr shifted tdi"}, bsr_m, din[BSR_LEN-1:0]);
    chk({tag, " R8 one update"}, upd_cnt - u0, 1);
  endtask

  task automatic t_tms_reset();
    logic [4:0] d, held;
    logic o;
    scan_ir(5'b11111, d, held);
    jbit(1, 0, o); jbit(0, 0, o); jbit(0, 0, o);
    for (int i = 0; i < 4; i++) jbit(1, 0, o);
    chk("R2 four tms-high edges keep ir", ir_out, 5'b11111);
    jbit(1, 0, o);
    chk("R2 fifth edge restores idcode", ir_out, 5'b00001);
    chk("R2 tdo_en low in reset", tdo_en, 1'b0);
    jbit(0, 0, o);
  endtask

  task automatic t_trst_midscan();
    logic [4:0] d, held;
    logic o;
    scan_ir(5'b00000, d, held);
    jbit(1, 0, o); jbit(0, 0, o); jbit(0, 0, o);
    trst_n = 1'b0; #1;
    chk("R1 async trst ir", ir_out, 5'b00001);
    chk("R1 async trst tdo_en", tdo_en, 1'b0);
    chk("R1 async trst extest off", extest_mode, 1'b0);
    do_reset();
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_idcode();
    t_ir_capture_and_update();
    t_tdo_edge();
    t_bypass(5'b11111, "R6 bypass delay");
    t_bypass(5'b10101, "R7 unlisted 10101 as bypass");
    t_bypass(5'b00100, "R7 unlisted 00100 as bypass");
    t_boundary(5'b00000, 1'b1, "extest");
    t_boundary(5'b00010, 1'b0, "sample");
    t_tms_reset();
    t_trst_midscan();
    t_idcode();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule